// File: doc/BRIEF.md
# Chunk ECC Syndrome Classifier and Corrector

This block compares the 24-bit error-correcting code read back from storage for one data chunk of up to 512 bytes with the 24-bit code freshly computed over the same data. Both codes arrive as inputs; generating the code from the data stream is done elsewhere. XORing the two codes gives a syndrome. The block decodes the syndrome into one of four outcomes: a clean chunk, a single flipped data bit that can be repaired, damage confined to the stored code bytes, or an uncorrectable error.

For a repairable data error the block reports which byte of the chunk and which bit inside that byte were flipped. When the caller enables fixing, the block repairs the flaw itself. It reads the byte from the chunk buffer over a simple byte port, inverts the bit and writes the byte back. Only then does it raise its done strobe. Results are registered and stay valid until the next accepted job.

A job is started with a one-cycle `start_i` pulse. The buffer port has a read latency of one cycle: data requested in one cycle is presented on `mem_rdata_i` in the following cycle. A write completes in the cycle it is issued.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: The syndrome is stored XOR computed, taken per byte as s0 = bits 7:0, s1 = bits 15:8 and s2 = bits 23:16. An all-zero syndrome yields status 0 (clean), with byte and bit index 0 and no buffer access.
- R2: When every syndrome byte has bits 1:0, 3:2, 5:4 and 7:6 each holding two different values, the status is 1 (data bit repairable).
- R3: For status 1 the bit index is {s2[6], s2[4], s2[2]}, most significant bit first.
- R4: For status 1 the byte index is {s2[0], s1[6], s1[4], s1[2], s1[0], s0[6], s0[4], s0[2], s0[0]}, most significant bit first.
- R5: A syndrome with exactly one of its 24 bits set yields status 2 (code bytes damaged), with both indices 0 and no buffer access.
- R6: Any other non-zero syndrome yields status 3 (uncorrectable), with both indices 0 and no buffer access.
- R7: When no buffer repair is made (fix_en_i low, or status other than 1), done_o is high in exactly the cycle after the accepted start.
- R8: With fix_en_i high and status 1, the block raises mem_rd_o for one cycle, in the cycle after start, with mem_addr_o set to the byte index. In the third cycle after start it raises mem_wr_o to the same address, with mem_wdata_o equal to the read byte XOR (1 << bit index). done_o is high in the fourth cycle after start, and no other buffer byte changes.
- R9: After reset done_o, mem_rd_o and mem_wr_o are low and status_o, byte_idx_o and bit_idx_o are 0.
- R10: A start pulse during a repair (the three cycles after an accepted repairing start) is ignored. It produces no done and does not change the results.
- R11: A start in the cycle where done_o is high is accepted. Status and indices hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle job request |
| fix_en_i | input | 1 | Repair the data byte when the error is repairable |
| stored_ecc_i | input | 24 | Code read back from storage, byte 0 in bits 7:0 |
| calc_ecc_i | input | 24 | Code computed over the data, same byte order |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 0 clean, 1 data repairable, 2 code damaged, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte of the chunk holding the flipped bit |
| bit_idx_o | output | 3 | Flipped bit inside that byte |
| mem_rd_o | output | 1 | Buffer read request |
| mem_wr_o | output | 1 | Buffer write request |
| mem_addr_o | output | 9 | Buffer byte address |
| mem_wdata_o | output | 8 | Repaired byte to write |
| mem_rdata_i | input | 8 | Buffer read data, one cycle after mem_rd_o |

## Verification
Two functions can meet in one cycle: the done strobe of one job and the start of the next. Every job in the bench is launched in the cycle where the previous done is visible, so the scoreboard only matches if each back-to-back start is taken. A second overlap comes from a start pulse raised in the middle of a read-modify-write. It is judged by the absence of any extra done, by the unchanged status, and by the buffer contents, which must differ from the shadow copy only in the single repaired bit.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   localparam int ECC_BYTES = 3;

   typedef enum logic [1:0] {
      ST_CLEAN    = 2'd0,
      ST_DATA_FIX = 2'd1,
      ST_ECC_AREA = 2'd2,
      ST_UNCORR   = 2'd3
   } ecc_stat_e;

   // a syndrome byte is a valid single-error image when each bit pair differs
   function automatic logic pair_ok(input logic [7:0] b);
      return ((b ^ (b >> 1)) & 8'h55) == 8'h55;
   endfunction

endpackage

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
   import ecc_fix_pkg::*;
#(
   parameter int IDX_W = 9,
   parameter int BIT_W = 3
) (
   input  logic [8*ECC_BYTES-1:0] stored_i,
   input  logic [8*ECC_BYTES-1:0] calc_i,
   output ecc_stat_e              stat_o,
   output logic [IDX_W-1:0]       byte_idx_o,
   output logic [BIT_W-1:0]       bit_idx_o
);
   localparam int SYN_W = 8 * ECC_BYTES;

   initial assert (2 * (IDX_W + BIT_W) <= SYN_W)
      else $error("index fields do not fit the syndrome");

   logic [SYN_W-1:0]     syn;
   logic [ECC_BYTES-1:0] lane_ok;
   logic [IDX_W-1:0]     raw_byte;
   logic [BIT_W-1:0]     raw_bit;
   logic                 all_ok;
   logic                 one_hot;

   assign syn = stored_i ^ calc_i;

   for (genvar g = 0; g < ECC_BYTES; g++) begin : g_lane
      assign lane_ok[g] = pair_ok(syn[g*8 +: 8]);
   end

   // the location is carried by the even syndrome bits, byte index first
   for (genvar n = 0; n < IDX_W; n++) begin : g_byte
      assign raw_byte[n] = syn[2*n];
   end
   for (genvar k = 0; k < BIT_W; k++) begin : g_bit
      assign raw_bit[k] = syn[2*(IDX_W+k)];
   end

   assign all_ok  = &lane_ok;
   assign one_hot = ($countones(syn) == 1);

   always_comb begin
      stat_o     = ST_UNCORR;
      byte_idx_o = '0;
      bit_idx_o  = '0;
      if (syn == '0) begin
         stat_o = ST_CLEAN;
      end else if (all_ok) begin
         stat_o     = ST_DATA_FIX;
         byte_idx_o = raw_byte;
         bit_idx_o  = raw_bit;
      end else if (one_hot) begin
         stat_o = ST_ECC_AREA;
      end
   end

endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq #(
   parameter int AW = 9,
   parameter int DW = 8,
   parameter int BW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] addr_i,
   input  logic [BW-1:0] bit_i,
   output logic          rd_o,
   output logic          wr_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   input  logic [DW-1:0] rdata_i,
   output logic          busy_o,
   output logic          fin_o
);
   typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} seq_e;

   seq_e          state_q;
   logic [AW-1:0] addr_q;
   logic [BW-1:0] bit_q;
   logic [DW-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         addr_q  <= '0;
         bit_q   <= '0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (go_i) begin
               state_q <= S_RD;
               addr_q  <= addr_i;
               bit_q   <= bit_i;
            end
            S_RD:   state_q <= S_WAIT;
            S_WAIT: begin
               state_q <= S_WR;
               wdata_q <= rdata_i ^ (DW'(1) << bit_q);
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign rd_o    = (state_q == S_RD);
   assign wr_o    = (state_q == S_WR);
   assign addr_o  = addr_q;
   assign wdata_o = wdata_q;
   assign busy_o  = (state_q != S_IDLE);
   assign fin_o   = wr_o;

   assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_o && wr_o));
   assert_rd_to_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |=> ##1 wr_o);

endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
   import ecc_fix_pkg::*;
#(
   parameter int CHUNK_BYTES = 512,
   parameter int DATA_W      = 8,
   parameter bit FIX_PRESENT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic                           fix_en_i,
   input  logic [8*ECC_BYTES-1:0]         stored_ecc_i,
   input  logic [8*ECC_BYTES-1:0]         calc_ecc_i,
   output logic                           done_o,
   output logic [1:0]                     status_o,
   output logic [$clog2(CHUNK_BYTES)-1:0] byte_idx_o,
   output logic [$clog2(DATA_W)-1:0]      bit_idx_o,
   output logic                           mem_rd_o,
   output logic                           mem_wr_o,
   output logic [$clog2(CHUNK_BYTES)-1:0] mem_addr_o,
   output logic [DATA_W-1:0]              mem_wdata_o,
   input  logic [DATA_W-1:0]              mem_rdata_i
);
   localparam int IDX_W = $clog2(CHUNK_BYTES);
   localparam int BIT_W = $clog2(DATA_W);

   initial assert (CHUNK_BYTES == 512) else $error("syndrome layout fixes the chunk at 512 bytes");
   initial assert (DATA_W == 8)        else $error("syndrome layout fixes the byte at 8 bits");

   ecc_stat_e        dec_st;
   logic [IDX_W-1:0] dec_byte;
   logic [BIT_W-1:0] dec_bit;
   logic             busy;
   logic             seq_fin;
   logic             accept;
   logic             need_fix;
   ecc_stat_e        st_q;
   logic [IDX_W-1:0] byte_q;
   logic [BIT_W-1:0] bit_q;
   logic             done_q;

   ecc_syn_decode #(.IDX_W(IDX_W), .BIT_W(BIT_W)) u_dec (
      .stored_i   (stored_ecc_i),
      .calc_i     (calc_ecc_i),
      .stat_o     (dec_st),
      .byte_idx_o (dec_byte),
      .bit_idx_o  (dec_bit)
   );

   assign accept   = start_i && !busy;
   assign need_fix = FIX_PRESENT && fix_en_i && (dec_st == ST_DATA_FIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_CLEAN;
         byte_q <= '0;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (accept && !need_fix) || seq_fin;
         if (accept) begin
            st_q   <= dec_st;
            byte_q <= dec_byte;
            bit_q  <= dec_bit;
         end
      end
   end

   if (FIX_PRESENT) begin : g_fix
      ecc_rmw_seq #(.AW(IDX_W), .DW(DATA_W), .BW(BIT_W)) u_seq (
         .clk     (clk),
         .rst_n   (rst_n),
         .go_i    (accept && need_fix),
         .addr_i  (dec_byte),
         .bit_i   (dec_bit),
         .rd_o    (mem_rd_o),
         .wr_o    (mem_wr_o),
         .addr_o  (mem_addr_o),
         .wdata_o (mem_wdata_o),
         .rdata_i (mem_rdata_i),
         .busy_o  (busy),
         .fin_o   (seq_fin)
      );
   end else begin : g_nofix
      assign mem_rd_o    = 1'b0;
      assign mem_wr_o    = 1'b0;
      assign mem_addr_o  = '0;
      assign mem_wdata_o = '0;
      assign busy        = 1'b0;
      assign seq_fin     = 1'b0;
   end

   assign done_o     = done_q;
   assign status_o   = st_q;
   assign byte_idx_o = byte_q;
   assign bit_idx_o  = bit_q;

   assert_quick_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && !fix_en_i) |=> done_o);
   assert_rd_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> (mem_addr_o == byte_idx_o));
   assert_wdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_wdata_o == ($past(mem_rdata_i) ^ (DATA_W'(1) << bit_idx_o))));
   assert_wr_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |=> done_o);
   assert_fix_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (status_o == ST_DATA_FIX));
   assert_idx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != ST_DATA_FIX) |-> (byte_idx_o == '0 && bit_idx_o == '0));
   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> $stable(status_o));

endmodule

// File: tb/ecc_syndrome_fixer_tb.sv
module ecc_syndrome_fixer_tb;
   import ecc_fix_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        fix_en_i = 1'b0;
   logic [23:0] stored_ecc_i = '0;
   logic [23:0] calc_ecc_i = '0;
   logic        done_o;
   logic [1:0]  status_o;
   logic [8:0]  byte_idx_o;
   logic [2:0]  bit_idx_o;
   logic        mem_rd_o, mem_wr_o;
   logic [8:0]  mem_addr_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;

   always #4 clk = ~clk;

   ecc_syndrome_fixer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fix_en_i(fix_en_i),
      .stored_ecc_i(stored_ecc_i), .calc_ecc_i(calc_ecc_i),
      .done_o(done_o), .status_o(status_o), .byte_idx_o(byte_idx_o),
      .bit_idx_o(bit_idx_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
   );

   // chunk buffer model: one-cycle read latency, write in the issuing cycle
   logic [7:0] mem    [0:511];
   logic [7:0] shadow [0:511];
   always @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
   end

   typedef struct packed {
      logic [1:0] st;
      logic [8:0] by;
      logic [2:0] bi;
   } exp_t;
   exp_t sbq[$];

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // builds a repairable syndrome: each even bit carries a location bit, its odd partner the inverse
   function automatic logic [23:0] mk_syn(input int by, input int bi);
      logic [23:0] s;
      logic [11:0] loc;
      loc = {bi[2:0], by[8:0]};
      for (int n = 0; n < 12; n++) begin
         s[2*n]   = loc[n];
         s[2*n+1] = ~loc[n];
      end
      return s;
   endfunction

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done_o && !ended) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R10", "done with no job pending", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(status_o == e.st, "R2", "status", status_o, e.st);
               chk(byte_idx_o == e.by, "R4", "byte index", byte_idx_o, e.by);
               chk(bit_idx_o == e.bi, "R3", "bit index", bit_idx_o, e.bi);
            end
         end
      end
   end

   // caller is at a negedge; returns at the negedge where done is visible
   task automatic job(input logic [23:0] sto, input logic [23:0] syn, input bit fix,
                      input logic [1:0] es, input int eby, input int ebi, input string req);
      exp_t e;
      e.st = es; e.by = eby[8:0]; e.bi = ebi[2:0];
      sbq.push_back(e);
      stored_ecc_i = sto;
      calc_ecc_i   = sto ^ syn;
      fix_en_i     = fix;
      start_i      = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (fix && es == ST_DATA_FIX) begin
         chk(mem_rd_o == 1'b1, "R8", "read strobe", mem_rd_o, 1);
         chk(mem_addr_o == eby[8:0], "R8", "read address", mem_addr_o, eby);
         @(negedge clk);
         chk(mem_wr_o == 1'b0 && done_o == 1'b0, "R8", "idle wait cycle", mem_wr_o, 0);
         @(negedge clk);
         shadow[eby] = shadow[eby] ^ (8'd1 << ebi);
         chk(mem_wr_o == 1'b1, "R8", "write strobe", mem_wr_o, 1);
         chk(mem_wdata_o == shadow[eby], "R8", "write data", mem_wdata_o, shadow[eby]);
         @(negedge clk);
         chk(done_o == 1'b1, "R8", "done after write", done_o, 1);
         chk(mem[eby] == shadow[eby], "R8", "buffer byte repaired", mem[eby], shadow[eby]);
      end else begin
         chk(done_o == 1'b1, {req, " R7"}, "done one cycle after start", done_o, 1);
         chk(mem_rd_o == 1'b0 && mem_wr_o == 1'b0, {req, " R7"}, "no buffer access", mem_rd_o, 0);
      end
   endtask

   task automatic buf_check(input string req);
      int bad;
      bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] != shadow[i]) bad++;
      chk(bad == 0, req, "buffer bytes differing from shadow", bad, 0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) begin
         mem[i]    = 8'(i * 37 + 5);
         shadow[i] = 8'(i * 37 + 5);
      end
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(done_o == 0 && mem_rd_o == 0 && mem_wr_o == 0, "R9", "strobes in reset", done_o, 0);
      chk(status_o == 0 && byte_idx_o == 0 && bit_idx_o == 0, "R9", "results in reset", status_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 0 && status_o == 0, "R9", "state after reset release", done_o, 0);

      // R1 clean chunk, fix enabled but nothing to do
      job(24'h5A3C96, 24'h000000, 1'b1, ST_CLEAN, 0, 0, "R1");
      // R2 R3 R4 repairs, each started in the previous done cycle (R11)
      job(24'h123456, mk_syn(0, 0), 1'b1, ST_DATA_FIX, 0, 0, "R4");
      job(24'hFEDCBA, mk_syn(511, 7), 1'b1, ST_DATA_FIX, 511, 7, "R3");
      job(24'h0F0F0F, mk_syn(9'h155, 5), 1'b1, ST_DATA_FIX, 9'h155, 5, "R4");
      // repairable but fixing disabled: reported only (R2, R7)
      job(24'hA5A5A5, mk_syn(9'h0AA, 2), 1'b0, ST_DATA_FIX, 9'h0AA, 2, "R2");
      buf_check("R2");
      // R5 single syndrome bit at the edges and middle
      job(24'h777777, 24'h000001, 1'b1, ST_ECC_AREA, 0, 0, "R5");
      job(24'h777777, 24'h800000, 1'b1, ST_ECC_AREA, 0, 0, "R5");
      job(24'h31415A, 24'h002000, 1'b1, ST_ECC_AREA, 0, 0, "R5");
      // R6 two equal bits in one pair; a repairable image with one pair broken
      job(24'h246802, 24'h000003, 1'b1, ST_UNCORR, 0, 0, "R6");
      job(24'h13579B, mk_syn(3, 1) ^ 24'h000100, 1'b1, ST_UNCORR, 0, 0, "R6");
      buf_check("R6");

      // R11 results hold while idle
      @(negedge clk);
      repeat (3) @(negedge clk);
      chk(status_o == ST_UNCORR && done_o == 0, "R11", "results held while idle", status_o, ST_UNCORR);

      // R10 start during a repair is ignored
      begin
         exp_t e;
         e.st = ST_DATA_FIX; e.by = 9'd77; e.bi = 3'd6;
         sbq.push_back(e);
         stored_ecc_i = 24'h0A0B0C;
         calc_ecc_i   = 24'h0A0B0C ^ mk_syn(77, 6);
         fix_en_i     = 1'b1;
         start_i      = 1'b1;
         @(negedge clk);
         stored_ecc_i = 24'h111111;
         calc_ecc_i   = 24'h111111;
         fix_en_i     = 1'b0;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         shadow[77] = shadow[77] ^ 8'h40;
         chk(mem_wr_o == 1'b1, "R10", "repair continues through stray start", mem_wr_o, 1);
         @(negedge clk);
         chk(done_o == 1'b1, "R10", "single done for the repair", done_o, 1);
         @(negedge clk);
         chk(done_o == 1'b0, "R10", "no done for stray start", done_o, 0);
         chk(status_o == ST_DATA_FIX, "R10", "status kept from repair", status_o, ST_DATA_FIX);
         buf_check("R10");
      end

      repeat (2) @(negedge clk);
      chk(sbq.size() == 0, "R7", "all expected results seen", sbq.size(), 0);
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         chk(1'b0, "R7", "watchdog expired", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule